// File: doc/BRIEF.md
# ATA Drive Bring-Up Sequencer

This block is a hardware state machine that takes an ATA drive from power-on to a usable state without software. It talks to the drive through a simple task-file access port. The port carries one register access at a time: an 8-bit read or write, or a 16-bit read of the data register. A single start pulse runs the whole bring-up. The block selects device 0 and waits for the drive to leave the busy state. It then pulses a soft reset and checks the register signature the drive leaves behind. Next it issues IDENTIFY and streams in the 256-word reply. Finally it programs multiple-sector mode.

While the reply streams in, the block keeps only the words it needs. From them it derives the addressing capability (LBA48, LBA28 or CHS), the total sector count, the CHS geometry and the multiple-sector count. When bring-up completes, ready is raised and the results are held. Any failed check parks the block in a fail state. Both terminal states stay put until the next start pulse.

Busy polling uses a cycle counter for the interval between status reads. It also caps the number of reads, so the same RTL runs with a millisecond interval on silicon and a few cycles in simulation.

Top module: `ata_bringup_seq`

## Requirements
- R1: After reset, ready_o, fail_o, tf_req_o, cap_o, sectors_o, the geometry outputs and mult_o are all zero.
- R2: A start pulse in idle, done or fail first writes 0x00 to the device-select register (address 6), then polls status.
- R3: A poll reads status (address 7). If BSY (bit 7) is set and fewer than MAX_POLLS reads have been made, the next read is issued exactly POLL_INTERVAL+1 cycles after the previous one was accepted. A poll ends after the first read with BSY clear, or after MAX_POLLS reads. The busy waits before reset and before IDENTIFY fail if BSY is still set at the end.
- R4: Soft reset writes 0x06 and then 0x02 to device control (address 14).
- R5: The signature is read from addresses 2, 3, 4, 5 and 7, in that order. The expected values are 0x01, 0x01, 0x00, 0x00 and nonzero. The first mismatch enters fail, and no further access is made.
- R6: After a busy wait, 0xEC is written to address 7. The block polls again. If DRQ (bit 3) is clear in the final status, it fails. Otherwise it makes 256 wide reads of the data register (address 0, tf_wide_o high, tf_we_o low).
- R7: The capability code is 2 (LBA48) if bit 10 of word 83 is set. Otherwise it is 1 (LBA28) if bit 9 of word 49 is set. Otherwise it is 0 (CHS).
- R8: For LBA48, sectors_o is {word 102, word 101, word 100}. Otherwise it is {16'h0, word 61, word 60}.
- R9: For LBA28 and CHS, cyl_o, heads_o and spt_o are words 1, 3 and 6. For LBA48 they are zero.
- R10: If the low byte of word 47 is nonzero, the block writes it to address 2, writes 0xC6 to address 7, and polls. mult_o takes that byte if ERR (bit 0) of the final status is clear, and 1 otherwise. If the byte is zero, no access is made and mult_o is 1.
- R11: ready_o and fail_o are never high together, and no access is made while either is high. Both hold until a start pulse, which clears them, cap_o, sectors_o and mult_o. A start pulse while the block is running is ignored.
- R12: Once tf_req_o is high, it and tf_we_o, tf_wide_o, tf_addr_o and tf_wdata_o hold steady until the cycle in which tf_ack_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a bring-up from idle, done or fail |
| tf_req_o | output | 1 | Task-file access request |
| tf_we_o | output | 1 | Access is a write |
| tf_wide_o | output | 1 | Access is a 16-bit data-register read |
| tf_addr_o | output | 4 | Task-file register address |
| tf_wdata_o | output | 16 | Write data (low byte used for 8-bit writes) |
| tf_ack_i | input | 1 | Access complete; read data valid this cycle |
| tf_rdata_i | input | 16 | Read data (low byte for 8-bit reads) |
| ready_o | output | 1 | Bring-up completed |
| fail_o | output | 1 | Bring-up failed |
| cap_o | output | 2 | Addressing capability: 0 CHS, 1 LBA28, 2 LBA48 |
| sectors_o | output | 48 | Total sector count |
| cyl_o | output | 16 | Cylinders (non-LBA48) |
| heads_o | output | 16 | Heads (non-LBA48) |
| spt_o | output | 16 | Sectors per track (non-LBA48) |
| mult_o | output | 8 | Adopted multiple-sector count |

## Verification
The assertions check four things on every cycle. Access requests stay stable until acknowledged. The terminal flags are mutually exclusive and hold between starts, and no access is issued while either is high. A completed result always carries a legal capability code, a nonzero multiple count and zero geometry for LBA48. Wide reads only ever target the data register as reads. Only the bench's scenarios can show that the access order and written values follow the bring-up sequence. They also show that the poll spacing and read cap are met, and that each signature, busy-timeout and DRQ failure stops the sequence at the right access. Finally, they show that the capability, sector count, geometry and multiple count are extracted correctly for each drive type and each response to the multiple-mode command.

// File: rtl/ata_bringup_pkg.sv
package ata_bringup_pkg;

  localparam logic [3:0] TF_DATA     = 4'h0;
  localparam logic [3:0] TF_SECCNT   = 4'h2;
  localparam logic [3:0] TF_SECNUM   = 4'h3;
  localparam logic [3:0] TF_CYL_LO   = 4'h4;
  localparam logic [3:0] TF_CYL_HI   = 4'h5;
  localparam logic [3:0] TF_DEVSEL   = 4'h6;
  localparam logic [3:0] TF_STAT_CMD = 4'h7;
  localparam logic [3:0] TF_DEVCTL   = 4'hE;

  localparam logic [7:0] CMD_IDENT    = 8'hEC;
  localparam logic [7:0] CMD_SET_MULT = 8'hC6;
  localparam logic [7:0] DCTL_RESET   = 8'h06;
  localparam logic [7:0] DCTL_RUN     = 8'h02;

  localparam int ST_BSY = 7;
  localparam int ST_DRQ = 3;
  localparam int ST_ERR = 0;

  localparam int W_CYL    = 1;
  localparam int W_HEADS  = 3;
  localparam int W_SPT    = 6;
  localparam int W_MULT   = 47;
  localparam int W_CAPS   = 49;
  localparam int W_LBA28  = 60;
  localparam int W_CMDSET = 83;
  localparam int W_LBA48  = 100;

  localparam int B_LBA28_EN = 9;
  localparam int B_LBA48_EN = 10;

  typedef enum logic [1:0] {
    CAP_CHS   = 2'd0,
    CAP_LBA28 = 2'd1,
    CAP_LBA48 = 2'd2
  } cap_e;

  typedef enum logic [1:0] {
    PK_PRE_RST,
    PK_PRE_ID,
    PK_DRQ,
    PK_MULT
  } poll_kind_e;

  typedef enum logic [4:0] {
    S_IDLE,
    S_DEVSEL,
    S_POLL_RD,
    S_POLL_WAIT,
    S_RST_ON,
    S_RST_OFF,
    S_SIG_SC,
    S_SIG_SN,
    S_SIG_CL,
    S_SIG_CH,
    S_SIG_ST,
    S_ID_CMD,
    S_ID_WORDS,
    S_MUL_CNT,
    S_MUL_CMD,
    S_DONE,
    S_FAIL
  } seq_state_e;

endpackage

// File: rtl/ata_poll_timer.sv
module ata_poll_timer #(
  parameter int POLL_INTERVAL = 50000,
  parameter int MAX_POLLS     = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic retry_i,
  output logic last_o,
  output logic expired_o
);
  localparam int ATT_W = (MAX_POLLS > 2) ? $clog2(MAX_POLLS) : 1;
  localparam int IVL_W = $clog2(POLL_INTERVAL + 1);

  logic [ATT_W-1:0] att_q;
  logic [IVL_W-1:0] ivl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      att_q <= '0;
    else if (clr_i)   att_q <= '0;
    else if (retry_i) att_q <= att_q + 1'b1;
  end

  // interval counts down while the sequencer waits between status reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ivl_q <= '0;
    else if (retry_i)       ivl_q <= IVL_W'(POLL_INTERVAL - 1);
    else if (ivl_q != '0)   ivl_q <= ivl_q - 1'b1;
  end

  assign last_o    = (att_q == ATT_W'(MAX_POLLS - 1));
  assign expired_o = (ivl_q == '0);

endmodule

// File: rtl/ata_ident_capture.sv
module ata_ident_capture
  import ata_bringup_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             vld_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [15:0]      word_i,
  output logic [1:0]       cap_o,
  output logic [47:0]      sectors_o,
  output logic [15:0]      cyl_o,
  output logic [15:0]      heads_o,
  output logic [15:0]      spt_o,
  output logic [7:0]       mult_raw_o
);
  localparam int N48 = 3;
  localparam int N28 = 2;

  logic [15:0] cyl_q, heads_q, spt_q;
  logic [7:0]  mult_q;
  logic        lba28_en_q, lba48_en_q;
  logic [16*N48-1:0] l48_cat;
  logic [16*N28-1:0] l28_cat;

  function automatic logic hit(input logic [IDX_W-1:0] idx, input int w);
    return idx == IDX_W'(w);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyl_q <= '0; heads_q <= '0; spt_q <= '0; mult_q <= '0;
      lba28_en_q <= 1'b0; lba48_en_q <= 1'b0;
    end else if (clr_i) begin
      cyl_q <= '0; heads_q <= '0; spt_q <= '0; mult_q <= '0;
      lba28_en_q <= 1'b0; lba48_en_q <= 1'b0;
    end else if (vld_i) begin
      if (hit(idx_i, W_CYL))    cyl_q      <= word_i;
      if (hit(idx_i, W_HEADS))  heads_q    <= word_i;
      if (hit(idx_i, W_SPT))    spt_q      <= word_i;
      if (hit(idx_i, W_MULT))   mult_q     <= word_i[7:0];
      if (hit(idx_i, W_CAPS))   lba28_en_q <= word_i[B_LBA28_EN];
      if (hit(idx_i, W_CMDSET)) lba48_en_q <= word_i[B_LBA48_EN];
    end
  end

  for (genvar k = 0; k < N48; k++) begin : g_l48
    logic [15:0] w_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               w_q <= '0;
      else if (clr_i)                            w_q <= '0;
      else if (vld_i && hit(idx_i, W_LBA48 + k)) w_q <= word_i;
    end
    assign l48_cat[16*k +: 16] = w_q;
  end

  for (genvar k = 0; k < N28; k++) begin : g_l28
    logic [15:0] w_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               w_q <= '0;
      else if (clr_i)                            w_q <= '0;
      else if (vld_i && hit(idx_i, W_LBA28 + k)) w_q <= word_i;
    end
    assign l28_cat[16*k +: 16] = w_q;
  end

  always_comb begin
    if (lba48_en_q)      cap_o = CAP_LBA48;
    else if (lba28_en_q) cap_o = CAP_LBA28;
    else                 cap_o = CAP_CHS;
  end

  assign sectors_o  = lba48_en_q ? l48_cat : {16'h0000, l28_cat};
  assign cyl_o      = lba48_en_q ? 16'h0000 : cyl_q;
  assign heads_o    = lba48_en_q ? 16'h0000 : heads_q;
  assign spt_o      = lba48_en_q ? 16'h0000 : spt_q;
  assign mult_raw_o = mult_q;

endmodule

// File: rtl/ata_bringup_seq.sv
module ata_bringup_seq
  import ata_bringup_pkg::*;
#(
  parameter int POLL_INTERVAL = 50000,
  parameter int MAX_POLLS     = 5000,
  parameter int ID_WORDS      = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output logic        tf_req_o,
  output logic        tf_we_o,
  output logic        tf_wide_o,
  output logic [3:0]  tf_addr_o,
  output logic [15:0] tf_wdata_o,
  input  logic        tf_ack_i,
  input  logic [15:0] tf_rdata_i,
  output logic        ready_o,
  output logic        fail_o,
  output logic [1:0]  cap_o,
  output logic [47:0] sectors_o,
  output logic [15:0] cyl_o,
  output logic [15:0] heads_o,
  output logic [15:0] spt_o,
  output logic [7:0]  mult_o
);
  localparam int IDX_W = $clog2(ID_WORDS);

  seq_state_e       state_q, state_d;
  poll_kind_e       kind_q, kind_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       mult_q, mult_d;
  logic             poll_clr, retry, cap_clr, word_vld;
  logic             last_try, ivl_done;
  logic [7:0]       st, mult_raw;

  assign st = tf_rdata_i[7:0];

  ata_poll_timer #(
    .POLL_INTERVAL(POLL_INTERVAL),
    .MAX_POLLS    (MAX_POLLS)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (poll_clr),
    .retry_i  (retry),
    .last_o   (last_try),
    .expired_o(ivl_done)
  );

  ata_ident_capture #(
    .IDX_W(IDX_W)
  ) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cap_clr),
    .vld_i     (word_vld),
    .idx_i     (idx_q),
    .word_i    (tf_rdata_i),
    .cap_o     (cap_o),
    .sectors_o (sectors_o),
    .cyl_o     (cyl_o),
    .heads_o   (heads_o),
    .spt_o     (spt_o),
    .mult_raw_o(mult_raw)
  );

  assign word_vld = (state_q == S_ID_WORDS) && tf_ack_i;

  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    idx_d    = idx_q;
    mult_d   = mult_q;
    poll_clr = 1'b0;
    retry    = 1'b0;
    cap_clr  = 1'b0;
    unique case (state_q)
      S_IDLE, S_DONE, S_FAIL: begin
        if (start_i) begin
          state_d = S_DEVSEL;
          mult_d  = '0;
          cap_clr = 1'b1;
        end
      end
      S_DEVSEL: if (tf_ack_i) begin
        state_d  = S_POLL_RD;
        kind_d   = PK_PRE_RST;
        poll_clr = 1'b1;
      end
      S_POLL_RD: if (tf_ack_i) begin
        if (st[ST_BSY] && !last_try) begin
          state_d = S_POLL_WAIT;
          retry   = 1'b1;
        end else begin
          unique case (kind_q)
            PK_PRE_RST: state_d = st[ST_BSY] ? S_FAIL : S_RST_ON;
            PK_PRE_ID:  state_d = st[ST_BSY] ? S_FAIL : S_ID_CMD;
            PK_DRQ: begin
              state_d = st[ST_DRQ] ? S_ID_WORDS : S_FAIL;
              idx_d   = '0;
            end
            PK_MULT: begin
              // count is kept only when the drive reports no error
              mult_d  = st[ST_ERR] ? 8'd1 : mult_raw;
              state_d = S_DONE;
            end
            default: state_d = S_FAIL;
          endcase
        end
      end
      S_POLL_WAIT: if (ivl_done) state_d = S_POLL_RD;
      S_RST_ON:    if (tf_ack_i) state_d = S_RST_OFF;
      S_RST_OFF:   if (tf_ack_i) state_d = S_SIG_SC;
      S_SIG_SC:    if (tf_ack_i) state_d = (st == 8'h01) ? S_SIG_SN : S_FAIL;
      S_SIG_SN:    if (tf_ack_i) state_d = (st == 8'h01) ? S_SIG_CL : S_FAIL;
      S_SIG_CL:    if (tf_ack_i) state_d = (st == 8'h00) ? S_SIG_CH : S_FAIL;
      S_SIG_CH:    if (tf_ack_i) state_d = (st == 8'h00) ? S_SIG_ST : S_FAIL;
      S_SIG_ST: if (tf_ack_i) begin
        if (st != 8'h00) begin
          state_d  = S_POLL_RD;
          kind_d   = PK_PRE_ID;
          poll_clr = 1'b1;
        end else begin
          state_d = S_FAIL;
        end
      end
      S_ID_CMD: if (tf_ack_i) begin
        state_d  = S_POLL_RD;
        kind_d   = PK_DRQ;
        poll_clr = 1'b1;
      end
      S_ID_WORDS: if (tf_ack_i) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == IDX_W'(ID_WORDS - 1)) begin
          if (mult_raw != 8'h00) begin
            state_d = S_MUL_CNT;
          end else begin
            mult_d  = 8'd1;
            state_d = S_DONE;
          end
        end
      end
      S_MUL_CNT: if (tf_ack_i) state_d = S_MUL_CMD;
      S_MUL_CMD: if (tf_ack_i) begin
        state_d  = S_POLL_RD;
        kind_d   = PK_MULT;
        poll_clr = 1'b1;
      end
      default: state_d = S_FAIL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= PK_PRE_RST;
      idx_q   <= '0;
      mult_q  <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      idx_q   <= idx_d;
      mult_q  <= mult_d;
    end
  end

  // access decode: every request comes straight from the registered state
  always_comb begin
    tf_req_o   = 1'b1;
    tf_we_o    = 1'b0;
    tf_wide_o  = 1'b0;
    tf_addr_o  = TF_STAT_CMD;
    tf_wdata_o = '0;
    unique case (state_q)
      S_DEVSEL:   begin tf_we_o = 1'b1; tf_addr_o = TF_DEVSEL; end
      S_POLL_RD:  tf_addr_o = TF_STAT_CMD;
      S_RST_ON:   begin tf_we_o = 1'b1; tf_addr_o = TF_DEVCTL; tf_wdata_o = {8'h00, DCTL_RESET}; end
      S_RST_OFF:  begin tf_we_o = 1'b1; tf_addr_o = TF_DEVCTL; tf_wdata_o = {8'h00, DCTL_RUN}; end
      S_SIG_SC:   tf_addr_o = TF_SECCNT;
      S_SIG_SN:   tf_addr_o = TF_SECNUM;
      S_SIG_CL:   tf_addr_o = TF_CYL_LO;
      S_SIG_CH:   tf_addr_o = TF_CYL_HI;
      S_SIG_ST:   tf_addr_o = TF_STAT_CMD;
      S_ID_CMD:   begin tf_we_o = 1'b1; tf_wdata_o = {8'h00, CMD_IDENT}; end
      S_ID_WORDS: begin tf_wide_o = 1'b1; tf_addr_o = TF_DATA; end
      S_MUL_CNT:  begin tf_we_o = 1'b1; tf_addr_o = TF_SECCNT; tf_wdata_o = {8'h00, mult_raw}; end
      S_MUL_CMD:  begin tf_we_o = 1'b1; tf_wdata_o = {8'h00, CMD_SET_MULT}; end
      default:    tf_req_o = 1'b0;
    endcase
  end

  assign ready_o = (state_q == S_DONE);
  assign fail_o  = (state_q == S_FAIL);
  assign mult_o  = mult_q;

endmodule

// File: rtl/ata_bringup_seq_chk.sv
module ata_bringup_seq_chk
  import ata_bringup_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        tf_req_o,
  input logic        tf_we_o,
  input logic        tf_wide_o,
  input logic [3:0]  tf_addr_o,
  input logic [15:0] tf_wdata_o,
  input logic        tf_ack_i,
  input logic        ready_o,
  input logic        fail_o,
  input logic [1:0]  cap_o,
  input logic [47:0] sectors_o,
  input logic [15:0] cyl_o,
  input logic [15:0] heads_o,
  input logic [15:0] spt_o,
  input logic [7:0]  mult_o
);

  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tf_req_o && !tf_ack_i |=> tf_req_o && $stable(tf_we_o) && $stable(tf_wide_o)
                              && $stable(tf_addr_o) && $stable(tf_wdata_o));

  p_term_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && fail_o));

  p_term_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o || fail_o) |-> !tf_req_o);

  p_done_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !start_i |=> ready_o && $stable(sectors_o) && $stable(mult_o) && $stable(cap_o));

  p_start_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o || fail_o) && start_i |=> !ready_o && !fail_o && mult_o == 8'h00
                                       && sectors_o == 48'h0);

  p_mult_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> mult_o != 8'h00);

  p_cap_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> cap_o != 2'd3);

  p_geom_lba48_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && cap_o == CAP_LBA48 |-> cyl_o == 16'h0 && heads_o == 16'h0 && spt_o == 16'h0);

  p_wide_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tf_req_o && tf_wide_o |-> tf_addr_o == TF_DATA && !tf_we_o);

endmodule

bind ata_bringup_seq ata_bringup_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .tf_req_o  (tf_req_o),
  .tf_we_o   (tf_we_o),
  .tf_wide_o (tf_wide_o),
  .tf_addr_o (tf_addr_o),
  .tf_wdata_o(tf_wdata_o),
  .tf_ack_i  (tf_ack_i),
  .ready_o   (ready_o),
  .fail_o    (fail_o),
  .cap_o     (cap_o),
  .sectors_o (sectors_o),
  .cyl_o     (cyl_o),
  .heads_o   (heads_o),
  .spt_o     (spt_o),
  .mult_o    (mult_o)
);

// File: tb/tb_ata_bringup_seq.sv
module tb_ata_bringup_seq;
  localparam int PI = 3;
  localparam int MP = 4;
  localparam int NW = 256;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic        ack = 1'b0;
  logic [15:0] rdata = '0;
  logic        tf_req_o, tf_we_o, tf_wide_o, ready_o, fail_o;
  logic [3:0]  tf_addr_o;
  logic [15:0] tf_wdata_o, cyl_o, heads_o, spt_o;
  logic [1:0]  cap_o;
  logic [47:0] sectors_o;
  logic [7:0]  mult_o;

  ata_bringup_seq #(.POLL_INTERVAL(PI), .MAX_POLLS(MP), .ID_WORDS(NW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .tf_req_o(tf_req_o), .tf_we_o(tf_we_o), .tf_wide_o(tf_wide_o),
    .tf_addr_o(tf_addr_o), .tf_wdata_o(tf_wdata_o),
    .tf_ack_i(ack), .tf_rdata_i(rdata),
    .ready_o(ready_o), .fail_o(fail_o), .cap_o(cap_o), .sectors_o(sectors_o),
    .cyl_o(cyl_o), .heads_o(heads_o), .spt_o(spt_o), .mult_o(mult_o)
  );

  // expected access script: one entry per task-file access
  typedef struct packed {
    logic        we;
    logic        wide;
    logic [3:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [7:0]  gap;
    logic [7:0]  rq;
  } txn_t;

  txn_t exp_a [0:4095];
  int   wr_ptr = 0;
  int   rd_ptr = 0, drop_cnt = 0, neg_cnt = 0, last_pop = 0;
  int   drv_chk = 0, drv_fail = 0;
  int   cmp_chk = 0, cmp_fail = 0;
  int   chk = 0, fails = 0;
  bit   scen_on = 1'b0, exp_good = 1'b0;
  int   cyc = 0;

  // drive model: accepts each request on a falling edge, acks for one cycle
  always @(negedge clk) begin
    txn_t t;
    neg_cnt++;
    if (ack) begin
      ack = 1'b0;
      drop_cnt++;
    end else if (tf_req_o) begin
      if (rd_ptr < wr_ptr) begin
        t = exp_a[rd_ptr];
        drv_chk++;
        if ({tf_we_o, tf_wide_o, tf_addr_o, tf_wdata_o} != {t.we, t.wide, t.addr, t.wdata}) begin
          drv_fail++;
          $display("FAIL R%0d access %0d: got we=%0b wide=%0b addr=%h wdata=%h exp we=%0b wide=%0b addr=%h wdata=%h",
                   t.rq, rd_ptr, tf_we_o, tf_wide_o, tf_addr_o, tf_wdata_o, t.we, t.wide, t.addr, t.wdata);
        end
        if (t.gap != 8'd0) begin
          drv_chk++;  // R3 poll spacing
          if (neg_cnt - last_pop != int'(t.gap)) begin
            drv_fail++;
            $display("FAIL R3 poll gap: got %0d exp %0d", neg_cnt - last_pop, t.gap);
          end
        end
        rdata = t.rdata;
        rd_ptr++;
      end else begin
        drv_chk++;
        drv_fail++;
        $display("FAIL R11 unexpected access addr=%h we=%0b: got 1 exp 0", tf_addr_o, tf_we_o);
        rdata = '0;
      end
      last_pop = neg_cnt;
      ack = 1'b1;
    end
  end

  // per-cycle comparison of terminal flags against the script position
  always begin
    bit term;
    @(negedge clk);
    #1;
    if (scen_on) begin
      term = (drop_cnt >= wr_ptr);
      cmp_chk++;
      if (ready_o !== (term && exp_good) || fail_o !== (term && !exp_good)) begin
        cmp_fail++;
        $display("FAIL R11 flags: got ready=%0b fail=%0b exp ready=%0b fail=%0b",
                 ready_o, fail_o, term && exp_good, term && !exp_good);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", chk + drv_chk + cmp_chk + 1, fails + drv_fail + cmp_fail + 1);
      $finish;
    end
  end

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    chk++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", rq, act, exp);
    end
  endtask

  task automatic push(input logic we, input logic wide, input logic [3:0] a, input logic [15:0] wd,
                      input logic [15:0] rd, input int gap, input int rq);
    exp_a[wr_ptr] = '{we: we, wide: wide, addr: a, wdata: wd, rdata: rd, gap: 8'(gap), rq: 8'(rq)};
    wr_ptr++;
  endtask

  // returns 1 if the poll ends with BSY still set
  task automatic push_poll(input int nbusy, input logic [7:0] fin, input int rq, output bit timed);
    timed = 1'b0;
    for (int j = 0; j < nbusy && j < MP; j++)
      push(1'b0, 1'b0, 4'h7, 16'h0, 16'h0080, (j > 0) ? PI + 1 : 0, rq);
    if (nbusy >= MP) timed = 1'b1;
    else push(1'b0, 1'b0, 4'h7, 16'h0, {8'h00, fin}, (nbusy > 0) ? PI + 1 : 0, rq);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_scn(input string tag, input int busy0, input bit sig_bad, input bit drq,
                         input int capk, input logic [7:0] mcnt, input bit mul_err, input bit mid);
    logic [15:0] img [NW];
    bit          alive, timed;
    int          n;
    logic [47:0] exp_sec;
    logic [7:0]  exp_mult;
    scen_on = 1'b0;
    for (int i = 0; i < NW; i++) img[i] = 16'h1000 + 16'(i);
    img[1]   = 16'd3000;
    img[3]   = 16'd16;
    img[6]   = 16'd63;
    img[47]  = {8'h80, mcnt};
    img[49]  = (capk >= 1) ? 16'h0F00 : 16'h0D00;
    img[60]  = 16'hBEEF;
    img[61]  = 16'h0123;
    img[83]  = (capk == 2) ? 16'h7400 : 16'h7B00;
    img[100] = 16'h1111;
    img[101] = 16'h2222;
    img[102] = 16'h0033;
    alive = 1'b1;
    push(1'b1, 1'b0, 4'h6, 16'h0000, 16'h0, 0, 2);      // R2
    push_poll(busy0, 8'h50, 3, timed);                  // R3
    if (timed) alive = 1'b0;
    if (alive) begin
      push(1'b1, 1'b0, 4'hE, 16'h0006, 16'h0, 0, 4);    // R4
      push(1'b1, 1'b0, 4'hE, 16'h0002, 16'h0, 0, 4);
      if (sig_bad) begin
        push(1'b0, 1'b0, 4'h2, 16'h0, 16'h0002, 0, 5);  // R5 mismatch stops here
        alive = 1'b0;
      end else begin
        push(1'b0, 1'b0, 4'h2, 16'h0, 16'h0001, 0, 5);
        push(1'b0, 1'b0, 4'h3, 16'h0, 16'h0001, 0, 5);
        push(1'b0, 1'b0, 4'h4, 16'h0, 16'h0000, 0, 5);
        push(1'b0, 1'b0, 4'h5, 16'h0, 16'h0000, 0, 5);
        push(1'b0, 1'b0, 4'h7, 16'h0, 16'h0050, 0, 5);
      end
    end
    if (alive) begin
      push_poll(0, 8'h50, 3, timed);
      push(1'b1, 1'b0, 4'h7, 16'h00EC, 16'h0, 0, 6);    // R6
      push_poll(1, drq ? 8'h58 : 8'h50, 6, timed);
      if (!drq) alive = 1'b0;
    end
    if (alive) begin
      for (int i = 0; i < NW; i++) push(1'b0, 1'b1, 4'h0, 16'h0, img[i], 0, 6);
      if (mcnt != 8'h00) begin
        push(1'b1, 1'b0, 4'h2, {8'h00, mcnt}, 16'h0, 0, 10);  // R10
        push(1'b1, 1'b0, 4'h7, 16'h00C6, 16'h0, 0, 10);
        push_poll(1, mul_err ? 8'h51 : 8'h50, 10, timed);
      end
    end
    exp_good = alive;
    pulse_start();
    scen_on = 1'b1;
    n = 0;
    while (drop_cnt < wr_ptr && n < 5000) begin
      @(negedge clk);
      n++;
      if (mid && n == 60) begin
        start = 1'b1;             // R11 start while running is ignored
        @(negedge clk);
        start = 1'b0;
        n++;
      end
    end
    repeat (3) @(negedge clk);
    #1;
    check({tag, " R11 script consumed"}, 64'(rd_ptr), 64'(wr_ptr));
    check({tag, " R11 ready"}, 64'(ready_o), 64'(alive));
    check({tag, " R11 fail"}, 64'(fail_o), 64'(!alive));
    if (alive) begin
      exp_sec  = (capk == 2) ? 48'h0033_2222_1111 : 48'h0000_0123_BEEF;
      exp_mult = (mcnt == 8'h00 || mul_err) ? 8'd1 : mcnt;
      check({tag, " R7 cap"}, 64'(cap_o), 64'(capk));
      check({tag, " R8 sectors"}, 64'(sectors_o), 64'(exp_sec));
      check({tag, " R9 cyl"}, 64'(cyl_o), (capk == 2) ? 64'd0 : 64'd3000);
      check({tag, " R9 heads"}, 64'(heads_o), (capk == 2) ? 64'd0 : 64'd16);
      check({tag, " R9 spt"}, 64'(spt_o), (capk == 2) ? 64'd0 : 64'd63);
      check({tag, " R10 mult"}, 64'(mult_o), 64'(exp_mult));
    end else begin
      // start cleared the results of the previous run (R11)
      check({tag, " R11 mult cleared"}, 64'(mult_o), 64'd0);
      check({tag, " R11 sectors cleared"}, 64'(sectors_o), 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 ready", 64'(ready_o), 64'd0);
    check("R1 fail", 64'(fail_o), 64'd0);
    check("R1 req", 64'(tf_req_o), 64'd0);
    check("R1 mult", 64'(mult_o), 64'd0);
    check("R1 sectors", 64'(sectors_o), 64'd0);
    check("R1 cap", 64'(cap_o), 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R1 idle after reset", 64'(tf_req_o), 64'd0);

    run_scn("lba48",      2, 1'b0, 1'b1, 2, 8'd16, 1'b0, 1'b1);  // R3 R6 R7 R8 R10 R11
    run_scn("lba28_err",  0, 1'b0, 1'b1, 1, 8'd8,  1'b1, 1'b0);  // R7 R10 ERR path
    run_scn("sig_bad",    0, 1'b1, 1'b1, 1, 8'd8,  1'b0, 1'b0);  // R5
    run_scn("chs_nomult", 1, 1'b0, 1'b1, 0, 8'd0,  1'b0, 1'b0);  // R9 R10 zero count
    run_scn("bsy_tmo",    MP, 1'b0, 1'b1, 2, 8'd4, 1'b0, 1'b0);  // R3 timeout
    run_scn("no_drq",     0, 1'b0, 1'b0, 2, 8'd4,  1'b0, 1'b0);  // R6 DRQ missing
    run_scn("mult_one",   0, 1'b0, 1'b1, 2, 8'd1,  1'b0, 1'b0);  // R10 boundary, R11 restart

    scen_on = 1'b0;
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", chk + drv_chk + cmp_chk, fails + drv_fail + cmp_fail);
    $finish;
  end

endmodule